// File: doc/BRIEF.md
# Lane-wise byte alignment shifter

This datapath block extracts a 16-byte window from a pair of vector operands, with each 128-bit lane handled on its own. Within every lane, the lane of the high operand sits above the matching lane of the low operand, giving a 32-byte temporary. That temporary is shifted right by an 8-bit unsigned byte count, and the low 16 bytes that remain become the lane result. Bytes never move from one lane to another.

The number of lanes is a parameter, and 1, 2 or 4 lanes are intended. A second parameter adds an optional output register with a valid flag. When it is off, the block is purely combinational. The usual use is to stitch together unaligned byte streams or to build sliding windows across two adjacent vector registers.

Top module: `lane_align_shifter`

## Requirements
- R1: Byte 0 of every bus is bits [7:0]. Lane k takes bits [128k+127:128k]. Output byte j of lane k is byte (j+s) of the 32-byte value {hi lane k, lo lane k}, or zero when j+s is 32 or more. Here s is `shift_i`. Each lane depends only on its own operand lanes.
- R2: A count of 0 returns the lo lane unchanged.
- R3: Any count from 32 to 255 makes every output byte zero.
- R4: A count of exactly 16 returns the hi lane unchanged.
- R5: For counts from 17 to 31, the result is the hi lane shifted right by (s-16) bytes, with the top (s-16) bytes zero.
- R6: For counts from 1 to 15, output bytes 0..15-s come from lo bytes s..15, and output bytes 16-s..15 come from hi bytes 0..s-1.
- R7: With REG_OUT=0, `data_o` and `valid_o` follow the inputs in the same cycle, and `valid_i` does not gate `data_o`.
- R8: With REG_OUT=1, `data_o` and `valid_o` appear one clock after the inputs. While `rst_ni` is low, both are zero.
- R9: With REG_OUT=1, a cycle with `valid_i` low leaves `data_o` unchanged and drives `valid_o` low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used only when REG_OUT=1 |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input operands and count are valid |
| shift_i | input | 8 | Unsigned byte shift count |
| hi_i | input | 128*NUM_LANES | High operand, the upper half of each lane pair |
| lo_i | input | 128*NUM_LANES | Low operand, the lower half of each lane pair |
| valid_o | output | 1 | Result valid |
| data_o | output | 128*NUM_LANES | Per-lane aligned result |

## Verification
The bench builds two instances. The first has four lanes and the output register, which covers the 512-bit case, the one-cycle latency, reset clearing and data holding while valid is low. The second has two lanes and no register, which exercises the purely combinational path and shows that `valid_i` does not gate its data. Both instances see all 256 shift counts with distinct data in every lane. Any byte leaking between lanes, or any error in the boundary counts 0, 15, 16, 17, 31 and 32, therefore shows up against a byte-wise reference model.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  localparam int LANE_W   = 128;
  localparam int LANE_B   = LANE_W / 8;
  localparam int PAIR_W   = 2 * LANE_W;
  localparam int SHIFT_W  = 8;
  localparam int STAGES   = $clog2(2 * LANE_B);

  typedef logic [SHIFT_W-1:0] shamt_t;
  typedef logic [LANE_W-1:0]  lane_t;
  typedef logic [PAIR_W-1:0]  pair_t;
endpackage

// File: rtl/lane_align_lane.sv
module lane_align_lane
  import lane_align_pkg::*;
(
  input  lane_t  hi_i,
  input  lane_t  lo_i,
  input  shamt_t shamt_i,
  output lane_t  res_o
);
  pair_t stg [STAGES+1];
  logic  far;

  assign stg[0] = {hi_i, lo_i};

  // log-depth barrel: stage g shifts by 2^g bytes
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign stg[g+1] = shamt_i[g] ? (stg[g] >> (8 * (1 << g))) : stg[g];
  end

  // any count bit above the pair width empties the window
  assign far   = |shamt_i[SHIFT_W-1:STAGES];
  assign res_o = far ? '0 : stg[STAGES][LANE_W-1:0];

  always_comb begin
    if (int'(shamt_i) >= 2 * LANE_B) a_r3_far_zero: assert (res_o == '0);
    if (int'(shamt_i) == LANE_B)     a_r4_hi_pass:  assert (res_o == hi_i);
    if (shamt_i == '0)               a_r2_lo_pass:  assert (res_o == lo_i);
  end
endmodule

// File: rtl/lane_align_out.sv
module lane_align_out #(
  parameter int W       = 512,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  if (REG_OUT) begin : g_reg
    logic         valid_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        data_q  <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) data_q <= data_i;
      end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

    a_r8_valid_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    a_r9_idle_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    a_r9_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(data_o));
  end else begin : g_comb
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end
endmodule

// File: rtl/lane_align_shifter.sv
module lane_align_shifter
  import lane_align_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [SHIFT_W-1:0]          shift_i,
  input  logic [NUM_LANES*LANE_W-1:0] hi_i,
  input  logic [NUM_LANES*LANE_W-1:0] lo_i,
  output logic                        valid_o,
  output logic [NUM_LANES*LANE_W-1:0] data_o
);
  localparam int VEC_W = NUM_LANES * LANE_W;

  logic [VEC_W-1:0] res;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    lane_align_lane u_lane (
      .hi_i    (hi_i[k*LANE_W +: LANE_W]),
      .lo_i    (lo_i[k*LANE_W +: LANE_W]),
      .shamt_i (shift_i),
      .res_o   (res[k*LANE_W +: LANE_W])
    );
  end

  lane_align_out #(
    .W       (VEC_W),
    .REG_OUT (REG_OUT)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (res),
    .valid_o (valid_o),
    .data_o  (data_o)
  );
endmodule

// File: tb/lane_align_shifter_tb_top.sv
module lane_align_shifter_tb_top;
  localparam int LW = 128;
  localparam int NL = 4;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [7:0] sh = '0;
  logic [NL*LW-1:0] hi = '0, lo = '0;
  logic vr, vc;
  logic [NL*LW-1:0] dr;
  logic [NC*LW-1:0] dc;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lane_align_shifter #(.NUM_LANES(NL), .REG_OUT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .shift_i(sh),
    .hi_i(hi), .lo_i(lo), .valid_o(vr), .data_o(dr));

  lane_align_shifter #(.NUM_LANES(NC), .REG_OUT(1'b0)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .shift_i(sh),
    .hi_i(hi[NC*LW-1:0]), .lo_i(lo[NC*LW-1:0]), .valid_o(vc), .data_o(dc));

  // {shift, seed}
  localparam logic [15:0] VEC_TBL [8] = '{
    16'h0001, 16'h0302, 16'h0703, 16'h0B04,
    16'h0F05, 16'h1306, 16'h1C07, 16'h1F08};

  function automatic logic [NL*LW-1:0] mk(input int seed, input int sel);
    logic [NL*LW-1:0] v;
    for (int k = 0; k < NL; k++)
      for (int b = 0; b < 16; b++)
        v[(k*16+b)*8 +: 8] = 8'((b*29 + k*71 + seed*13 + sel*101) ^ (sel != 0 ? 8'hA5 : 8'h3C));
    return v;
  endfunction

  function automatic logic [NL*LW-1:0] ref_vec(input logic [NL*LW-1:0] h, l, input int s);
    logic [NL*LW-1:0] r;
    for (int k = 0; k < NL; k++)
      for (int j = 0; j < 16; j++) begin
        int idx = j + s;
        if (idx < 16)      r[(k*16+j)*8 +: 8] = l[(k*16+idx)*8 +: 8];
        else if (idx < 32) r[(k*16+j)*8 +: 8] = h[(k*16+idx-16)*8 +: 8];
        else               r[(k*16+j)*8 +: 8] = 8'h00;
      end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [NL*LW-1:0] act, input logic [NL*LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int s);
    if (s == 0)  return "R2";
    if (s == 16) return "R4";
    if (s >= 32) return "R3";
    if (s > 16)  return "R5";
    return "R6";
  endfunction

  // drive at negedge, check comb after settle, check registered one clock later
  task automatic run(input int s, input int seed, input string tag);
    logic [NL*LW-1:0] e;
    @(negedge clk);
    sh = 8'(s); hi = mk(seed, 1); lo = mk(seed, 0); vld = 1'b1;
    #1;
    e = ref_vec(hi, lo, s);
    chk({tag, " comb R7"}, {{(NL-NC)*LW{1'b0}}, dc}, {{(NL-NC)*LW{1'b0}}, e[NC*LW-1:0]});
    chk("R7 comb valid", {{(NL*LW-1){1'b0}}, vc}, {{(NL*LW-1){1'b0}}, 1'b1});
    @(negedge clk);
    chk({tag, " reg R8"}, dr, e);
    chk("R8 reg valid", {{(NL*LW-1){1'b0}}, vr}, {{(NL*LW-1){1'b0}}, 1'b1});
  endtask

  initial begin
    #(8*150000);
    n_fail++;
    $display("FAIL R8 watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NL*LW-1:0] held;
    #20;
    chk("R8 reset data", dr, '0);
    chk("R8 reset valid", {{(NL*LW-1){1'b0}}, vr}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R1 lane composition
    for (int i = 0; i < 8; i++)
      run(int'(VEC_TBL[i][15:8]), int'(VEC_TBL[i][7:0]), "R1");

    // full sweep of counts
    for (int s = 0; s < 256; s++)
      run(s, s + 40, tag_of(s));

    // directed corners against explicit forms
    run(0, 3, "R2");
    chk("R2 lo pass", dr, lo);
    run(16, 4, "R4");
    chk("R4 hi pass", dr, hi);
    run(32, 5, "R3");
    chk("R3 zero at 32", dr, '0);
    run(255, 6, "R3");
    chk("R3 zero at 255", dr, '0);
    run(15, 7, "R6");
    for (int k = 0; k < NL; k++)
      chk("R6 count 15", {{(NL-1)*LW{1'b0}}, dr[k*LW +: LW]},
          {{(NL-1)*LW{1'b0}}, hi[k*LW +: LW-8], lo[k*LW+LW-8 +: 8]});
    run(20, 8, "R5");
    for (int k = 0; k < NL; k++)
      chk("R5 count 20", {{(NL-1)*LW{1'b0}}, dr[k*LW +: LW]},
          {{(NL-1)*LW{1'b0}}, hi[k*LW +: LW] >> 32});
    run(31, 9, "R5");
    for (int k = 0; k < NL; k++)
      chk("R5 count 31", {{(NL-1)*LW{1'b0}}, dr[k*LW +: LW]},
          {{(NL-1)*LW{1'b0}}, {(LW-8){1'b0}}, hi[k*LW+LW-8 +: 8]});

    // hold while invalid
    run(5, 10, "R9");
    held = dr;
    @(negedge clk);
    vld = 1'b0; sh = 8'd0; hi = ~hi; lo = mk(77, 0);
    #1;
    chk("R7 comb ignores valid", {{(NL-NC)*LW{1'b0}}, dc}, {{(NL-NC)*LW{1'b0}}, lo[NC*LW-1:0]});
    chk("R7 comb valid low", {{(NL*LW-1){1'b0}}, vc}, '0);
    @(negedge clk);
    chk("R9 hold data", dr, held);
    chk("R9 valid drop", {{(NL*LW-1){1'b0}}, vr}, '0);
    @(negedge clk);
    chk("R9 hold data 2", dr, held);

    // asynchronous reset mid-run
    run(3, 11, "R8");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear data", dr, '0);
    chk("R8 async clear valid", {{(NL*LW-1){1'b0}}, vr}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    run(1, 12, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule